// File: doc/BRIEF.md
# Single-Wire Factory ID Reader

This block is the master side of a single-wire bus. It reads the 64-bit factory identity word out of one slave device through an open-drain data line. The line carries both the data and the device's supply, so the block leaves it released (pulled high) whenever it is not timing a slot.

A transaction starts on a one-cycle `start` strobe. The block drives a long low reset pulse, releases the line and checks for a presence response. It then writes the read-identity command and clocks in 64 bits. As the bits arrive, it runs a CRC over them and parses the word into a family byte, a 48-bit serial number and a check byte. At the end it raises `done` for one cycle. It then presents the serial number along with one good flag and three error flags. All slot timing is counted in microsecond ticks taken from a system-clock divider.

Top module: `owid_reader`

## Requirements
- R1: After reset `busy`, `done`, `id_valid`, `err_nodev`, `err_family` and `err_crc` are 0, and `ow_drive_low` is 0 in every cycle in which `busy` is 0.
- R2: A `start` strobe while idle sets `busy` in the next cycle. The first action is a low pulse lasting exactly `T_RST` microseconds.
- R3: The line is sampled `T_RST+T_PRES` microseconds after the reset pulse begins. If it reads high there, the block ends with `err_nodev`=1, `id_valid`=0 and `serial`=0, and it issues no command or read slots.
- R4: After a presence response, the command byte 33h is written least significant bit first, one slot per bit. A 1 holds the line low for `T_LOW1` microseconds, a 0 for `T_LOW0` microseconds, and every slot lasts `T_SLOT` microseconds.
- R5: Exactly 64 read slots follow the command. Each holds the line low for `T_LOW1` microseconds and samples it at `T_SAMP`. The bits arrive least significant first: bits 0..7 are the family byte, bits 8..55 the serial number (bit 8 is serial bit 0), and bits 56..63 the check byte.
- R6: `id_valid` is 1 exactly when the family byte is 01h and the check passes. `serial` then equals bits 55..8 of the received word.
- R7: A family byte other than 01h sets `err_family`.
- R8: The check is a reflected CRC-8 with polynomial x^8+x^5+x^4+1 (feedback value 8Ch, initial value 0). It is computed over the first 56 bits and must equal the check byte. A mismatch sets `err_crc`.
- R9: A `start` strobe while `busy` is 1 has no effect on the running transaction.
- R10: `done` pulses for exactly one cycle, in the cycle `busy` falls. The status outputs hold their values until the next accepted `start`.
- R11: One microsecond is exactly `CLK_DIV` clock cycles, so every low interval lasts its microsecond count times `CLK_DIV` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to read the identity |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| ow_drive_low | output | 1 | 1 pulls the open-drain data line low |
| ow_sense | input | 1 | Sensed level of the data line |
| serial | output | 48 | Parsed serial number |
| id_valid | output | 1 | Family byte and check are both good |
| err_nodev | output | 1 | No presence response seen |
| err_family | output | 1 | Family byte is not 01h |
| err_crc | output | 1 | Check byte mismatch |

## Verification
The bench builds the block with `CLK_DIV`=2 and slot timings scaled down to tens of microseconds: a 48 us reset pulse, 14 us slots, 2/12 us write lows and a sample at 6 us. A full read then takes about two thousand cycles. That brings a dozen complete transactions within reach, each against a cycle-level model of the slave. The runs sweep serial patterns (all zeros, all ones, alternating bits, walking ones, a mixed word) and cover a wrong family byte, a corrupted check byte, both faults together, an absent device and a start during a busy run. A divider of 2 makes the exact cycle lengths of the reset and write lows show whether the tick divider is right.

// File: rtl/owid_pkg.sv
package owid_pkg;

  typedef enum logic [1:0] {
    SK_RST = 2'd0,
    SK_WR  = 2'd1,
    SK_RD  = 2'd2
  } slot_kind_e;

  localparam logic [7:0] FAMILY_ID    = 8'h01;
  localparam logic [7:0] READ_ID_CMD  = 8'h33;
  localparam logic [7:0] CRC_FEEDBACK = 8'h8C;

  // one bit of the reflected CRC-8, least significant data bit first
  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    crc8_step = (c >> 1) ^ (fb ? CRC_FEEDBACK : 8'h00);
  endfunction

endpackage

// File: rtl/owid_ticker.sv
module owid_ticker #(
  parameter int CLK_DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(CLK_DIV - 1);

  logic [DW-1:0] cnt;

  assign tick = !clr && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (clr)      cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  generate
    if (CLK_DIV > 1) begin : g_gap
      p_tick_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/owid_slot.sv
module owid_slot import owid_pkg::*; #(
  parameter int T_RST  = 480,
  parameter int T_PRES = 70,
  parameter int T_RSTH = 960,
  parameter int T_LOW0 = 60,
  parameter int T_LOW1 = 6,
  parameter int T_SAMP = 15,
  parameter int T_SLOT = 70
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       go,
  input  slot_kind_e kind,
  input  logic       wbit,
  input  logic       line_in,
  output logic       drive_low,
  output logic       sample_stb,
  output logic       bit_out,
  output logic       done
);
  localparam int CW = $clog2(T_RSTH + 1);

  slot_kind_e    kind_q;
  logic          wbit_q;
  logic          active;
  logic [CW-1:0] ucnt;
  logic [CW:0]   ucnt_nxt;
  logic [CW-1:0] low_at, end_at, samp_at;
  logic [1:0]    sync;
  logic          line_s;

  always_comb begin
    low_at  = CW'(T_LOW1);
    end_at  = CW'(T_SLOT);
    samp_at = '0;
    unique case (kind_q)
      SK_RST: begin
        low_at  = CW'(T_RST);
        end_at  = CW'(T_RSTH);
        samp_at = CW'(T_RST + T_PRES);
      end
      SK_WR:   low_at  = wbit_q ? CW'(T_LOW1) : CW'(T_LOW0);
      SK_RD:   samp_at = CW'(T_SAMP);
      default: ;
    endcase
  end

  assign ucnt_nxt   = {1'b0, ucnt} + 1'b1;
  assign line_s     = sync[1];
  assign drive_low  = active && (ucnt < low_at);
  assign sample_stb = active && tick && (ucnt_nxt == {1'b0, samp_at});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], line_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= SK_RST;
      wbit_q  <= 1'b1;
      active  <= 1'b0;
      ucnt    <= '0;
      bit_out <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        kind_q <= kind;
        wbit_q <= wbit;
        active <= 1'b1;
        ucnt   <= '0;
      end else if (active && tick) begin
        ucnt <= ucnt_nxt[CW-1:0];
        if (sample_stb) bit_out <= line_s;
        if (ucnt_nxt == {1'b0, end_at}) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  // the line is read only after the master has let go of it
  p_sample_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> !drive_low);
  // a slot ends with the line released
  p_slot_end_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !drive_low);
  p_go_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !active);
endmodule

// File: rtl/owid_reader.sv
module owid_reader import owid_pkg::*; #(
  parameter int CLK_DIV = 100,
  parameter int T_RST   = 480,
  parameter int T_PRES  = 70,
  parameter int T_RSTH  = 960,
  parameter int T_LOW0  = 60,
  parameter int T_LOW1  = 6,
  parameter int T_SAMP  = 15,
  parameter int T_SLOT  = 70
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        busy,
  output logic        done,
  output logic        ow_drive_low,
  input  logic        ow_sense,
  output logic [47:0] serial,
  output logic        id_valid,
  output logic        err_nodev,
  output logic        err_family,
  output logic        err_crc
);
  localparam int ID_BITS = 64;

  typedef enum logic [2:0] {ST_IDLE, ST_RST, ST_CMD, ST_READ, ST_FIN} st_e;

  st_e        st;
  logic [5:0] idx;
  logic [63:0] rom;
  logic [7:0] crc;
  logic       go, wbit, no_dev;
  slot_kind_e kind;
  logic       tick, slot_done, slot_bit, slot_smp;
  logic       launch, presence_seen, last_read;
  logic [2:0] cmd_nxt;
  logic       fam_ok, crc_ok;

  assign busy          = (st != ST_IDLE);
  assign launch        = start && !busy;
  assign presence_seen = slot_done && (st == ST_RST) && !slot_bit;
  assign last_read     = (idx == 6'(ID_BITS - 1));
  assign cmd_nxt       = idx[2:0] + 3'd1;
  assign fam_ok        = (rom[7:0] == FAMILY_ID);
  assign crc_ok        = (crc == 8'h00);

  owid_ticker #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(go), .tick(tick)
  );

  owid_slot #(
    .T_RST(T_RST), .T_PRES(T_PRES), .T_RSTH(T_RSTH), .T_LOW0(T_LOW0),
    .T_LOW1(T_LOW1), .T_SAMP(T_SAMP), .T_SLOT(T_SLOT)
  ) u_slot (
    .clk(clk), .rst_n(rst_n), .tick(tick), .go(go), .kind(kind), .wbit(wbit),
    .line_in(ow_sense), .drive_low(ow_drive_low), .sample_stb(slot_smp),
    .bit_out(slot_bit), .done(slot_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; idx <= '0; rom <= '0; crc <= '0;
      go <= 1'b0; wbit <= 1'b1; kind <= SK_RST; no_dev <= 1'b0;
      done <= 1'b0; serial <= '0; id_valid <= 1'b0;
      err_nodev <= 1'b0; err_family <= 1'b0; err_crc <= 1'b0;
    end else begin
      go   <= 1'b0;
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (launch) begin
          st <= ST_RST; go <= 1'b1; kind <= SK_RST; idx <= '0; crc <= '0;
          no_dev <= 1'b0; id_valid <= 1'b0;
          err_nodev <= 1'b0; err_family <= 1'b0; err_crc <= 1'b0;
        end
        ST_RST: if (slot_done) begin
          if (presence_seen) begin
            st <= ST_CMD; go <= 1'b1; kind <= SK_WR; wbit <= READ_ID_CMD[0];
          end else begin
            st <= ST_FIN; no_dev <= 1'b1;
          end
        end
        ST_CMD: if (slot_done) begin
          go <= 1'b1;
          if (idx[2:0] == 3'd7) begin
            st <= ST_READ; idx <= '0; kind <= SK_RD;
          end else begin
            idx <= idx + 1'b1; wbit <= READ_ID_CMD[cmd_nxt];
          end
        end
        ST_READ: if (slot_done) begin
          rom <= {slot_bit, rom[63:1]};
          crc <= crc8_step(crc, slot_bit);
          if (last_read) st <= ST_FIN;
          else begin idx <= idx + 1'b1; go <= 1'b1; end
        end
        ST_FIN: begin
          st <= ST_IDLE; done <= 1'b1;
          if (no_dev) begin
            serial <= '0; err_nodev <= 1'b1;
          end else begin
            serial     <= rom[55:8];
            err_family <= !fam_ok;
            err_crc    <= !crc_ok;
            id_valid   <= fam_ok && crc_ok;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ow_drive_low);
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);
  p_nodev_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_nodev) |-> (serial == 48'd0 && !id_valid));
  p_status_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({id_valid, err_nodev, err_family | err_crc}));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_hold_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !launch) |=> $stable(serial));
endmodule

// File: tb/tb_owid_reader.sv
module tb_owid_reader;
  localparam int DIV = 2;

  logic clk = 0, rst_n = 0, start = 0;
  logic busy, done, ow_drive_low, id_valid, err_nodev, err_family, err_crc;
  logic [47:0] serial;
  logic dev_low = 0;
  logic ow_sense;

  assign ow_sense = !(ow_drive_low || dev_low);
  always #5 clk = ~clk;

  owid_reader #(
    .CLK_DIV(DIV), .T_RST(48), .T_PRES(8), .T_RSTH(96), .T_LOW0(12),
    .T_LOW1(2), .T_SAMP(6), .T_SLOT(14)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .ow_drive_low(ow_drive_low), .ow_sense(ow_sense), .serial(serial),
    .id_valid(id_valid), .err_nodev(err_nodev), .err_family(err_family),
    .err_crc(err_crc)
  );

  int total = 0, bad = 0, cycles = 0;

  // slave model state
  logic present = 1;
  logic [63:0] id_word = '0;
  int phase = 0, low_len = 0, hold = 0, pres_t = 0;
  int nrst = 0, rst_len = 0, ncmd = 0, nread = 0, wr1_len = 0, wr0_len = 0, ndone = 0;
  logic [7:0] cmd_rx = '0;
  logic prev_m = 0;

  always @(negedge clk) begin
    cycles++;
    if (done) ndone++;
    if (ow_drive_low) low_len++;
    if (ow_drive_low && !prev_m && phase == 2 && nread < 64) begin
      if (!id_word[nread]) hold = 16;
      nread++;
    end
    if (!ow_drive_low && prev_m) begin
      if (low_len >= 60) begin
        nrst++; rst_len = low_len; phase = 1; ncmd = 0;
        if (present) pres_t = 1;
      end else if (phase == 1 && ncmd < 8) begin
        cmd_rx[ncmd] = (low_len < 12);
        if (low_len < 12) wr1_len = low_len; else wr0_len = low_len;
        ncmd++;
        if (ncmd == 8) phase = 2;
      end
      low_len = 0;
    end
    if (hold > 0) hold--;
    if (pres_t > 0) pres_t = (pres_t >= 40) ? 0 : pres_t + 1;
    dev_low = (hold > 0) || (pres_t >= 4 && pres_t < 28);
    prev_m = ow_drive_low;
  end

  always @(negedge clk) begin
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_crc(input logic [55:0] d);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      logic mix;
      mix = c[0] ^ d[i];
      c = {1'b0, c[7:1]};
      if (mix) begin c[7] = ~c[7]; c[3] = ~c[3]; c[2] = ~c[2]; end
    end
    return c;
  endfunction

  function automatic logic [63:0] mk_id(input logic [7:0] fam, input logic [47:0] sn, input logic [7:0] flip);
    logic [55:0] body;
    body = {sn, fam};
    return {ref_crc(body) ^ flip, body};
  endfunction

  task automatic run(input logic pres, input logic [63:0] word, input logic poke);
    int guard = 0;
    int d0;
    logic [7:0] fam;
    logic exp_fam_ok, exp_crc_ok;
    present = pres; id_word = word;
    nrst = 0; ncmd = 0; nread = 0; phase = 0; cmd_rx = '0;
    wr1_len = 0; wr0_len = 0; d0 = ndone;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk(busy == 1, "R2 busy after start", 64'(busy), 64'd1);
    if (poke) begin
      repeat (300) @(negedge clk);
      start = 1; @(negedge clk); start = 0;
    end
    while (busy && guard < 20000) begin @(negedge clk); guard++; end
    @(negedge clk);
    chk(rst_len == 48*DIV, "R11 reset low cycles", 64'(rst_len), 64'(48*DIV));
    chk(ndone == d0 + 1, "R10 one done pulse", 64'(ndone - d0), 64'd1);
    if (!pres) begin
      chk(err_nodev && !id_valid && serial == 0, "R3 no device flags",
          {err_nodev, id_valid, serial}, {2'b10, 48'd0});
      chk(ncmd == 0 && nread == 0, "R3 no slots after absent", 64'(ncmd + nread), 64'd0);
    end else begin
      fam = word[7:0];
      exp_fam_ok = (fam == 8'h01);
      exp_crc_ok = (word[63:56] == ref_crc(word[55:0]));
      chk(nrst == 1, "R9 single reset pulse", 64'(nrst), 64'd1);
      chk(ncmd == 8 && cmd_rx == 8'h33, "R4 command byte", 64'(cmd_rx), 64'h33);
      chk(wr1_len == 2*DIV && wr0_len == 12*DIV, "R4 write low lengths",
          64'(wr1_len * 1000 + wr0_len), 64'(2*DIV*1000 + 12*DIV));
      chk(nread == 64, "R5 read slot count", 64'(nread), 64'd64);
      chk(serial == word[55:8], "R5 serial field", 64'(serial), 64'(word[55:8]));
      chk(id_valid == (exp_fam_ok && exp_crc_ok), "R6 valid flag", 64'(id_valid), 64'(exp_fam_ok && exp_crc_ok));
      chk(err_family == !exp_fam_ok, "R7 family flag", 64'(err_family), 64'(!exp_fam_ok));
      chk(err_crc == !exp_crc_ok, "R8 crc flag", 64'(err_crc), 64'(!exp_crc_ok));
      chk(!err_nodev, "R3 presence seen", 64'(err_nodev), 64'd0);
    end
    // status holds while idle
    repeat (20) @(negedge clk);
    chk(!busy && !ow_drive_low, "R1 idle line released", {busy, ow_drive_low}, 64'd0);
    chk(serial == (pres ? word[55:8] : 48'd0), "R10 status held", 64'(serial), 64'(pres ? word[55:8] : 48'd0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, done, id_valid, err_nodev, err_family, err_crc, ow_drive_low} == 0,
        "R1 reset state", {busy, done, id_valid, err_nodev, err_family, err_crc, ow_drive_low}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!busy && !ow_drive_low, "R1 idle after reset", {busy, ow_drive_low}, 64'd0);
    run(1, mk_id(8'h01, 48'h0, 8'h00), 0);
    run(1, mk_id(8'h01, 48'hFFFF_FFFF_FFFF, 8'h00), 0);
    run(1, mk_id(8'h01, 48'hAAAA_AAAA_AAAA, 8'h00), 0);
    run(1, mk_id(8'h01, 48'h5555_5555_5555, 8'h00), 0);
    for (int k = 0; k < 4; k++) run(1, mk_id(8'h01, 48'd1 << (k * 13), 8'h00), 0);
    run(1, mk_id(8'h01, 48'h1234_5678_9ABC, 8'h00), 0);
    run(1, mk_id(8'h28, 48'h0F0F_3C3C_A5A5, 8'h00), 0);
    run(1, mk_id(8'h01, 48'h0F0F_3C3C_A5A5, 8'h10), 0);
    run(1, mk_id(8'hFE, 48'hDEAD_BEEF_0001, 8'h81), 0);
    run(0, 64'd0, 0);
    run(1, mk_id(8'h01, 48'hC0FF_EE00_1234, 8'h00), 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule